// File: doc/BRIEF.md
# Jittered Switching Oscillator with Duty Ceiling

This block is the timing heart of a current-mode switching regulator controller. A free-running counter divides the system clock down to the switching rate, nominally 65 kHz, and exposes its in-period count as a digital ramp for slope compensation. To spread conducted emissions, the period length is moved up and down by a slow triangular envelope spanning roughly 4 ms. The period length changes only at period boundaries, so no cycle is ever cut short.

At each period start the block emits a set pulse and turns the gate on. A blank input from the burst logic can suppress that start. The counter and the envelope still keep running while the start is suppressed. The gate ends either when the peak-current comparator requests a cycle reset or at the 75 % duty ceiling, whichever comes first. The comparator request is ignored for a short leading-edge window after turn-on. The center frequency, jitter depth, envelope length, duty ceiling and blanking window are all given in physical units and converted to clock counts from the clock frequency parameter.

Top module: `pwm_jitter_osc`

## Requirements
- R1: While the reset is asserted, and during the two clocks of its synchronous release, `ramp_o` is 0 and `gate_o` and `set_o` are low.
- R2: `ramp_o` rises by one every clock from 0 to P-1, where P is the length of the current period, and then returns to 0.
- R3: The first period after reset is exactly N = CLK_HZ/F_SW_HZ clocks long. Each later period is N plus the envelope offset held when that period began.
- R4: The envelope offset starts at 0, rising. It moves by one count every D periods, with D = max(1, (ENV_US·F_SW_HZ/10^6)/(4J)). It turns around on reaching +J or -J, with J = N·JIT_PCT/100. The period lengths seen therefore span exactly N-J to N+J.
- R5: The envelope repeats every 4·J·D periods.
- R6: A new period length and duty limit take effect only when `ramp_o` returns to 0. Within a period neither changes.
- R7: `set_o` is high exactly when `ramp_o` is 0, the reset has been released and `blank_i` is low. When `blank_i` is high at that point, the gate stays off for that period, but the ramp and the envelope keep advancing.
- R8: After an unblanked start, `gate_o` is high for ramp values 1 through L, where L = floor(P·DUTY_PCT/100). With no cycle reset, that is L clocks of on time.
- R9: `cyc_rst_i` seen at a clock edge while `gate_o` is high and `ramp_o` is greater than B, where B = (CLK_HZ/1000)·LEB_NS/10^6, turns `gate_o` low from the next clock. The request is ignored while `ramp_o` is B or less.
- R10: `lim_o` is high exactly when `ramp_o` equals the current duty limit L.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blank_i | input | 1 | Suppresses the start of a period while high |
| cyc_rst_i | input | 1 | Peak-current comparator request to end the on time |
| set_o | output | 1 | Period start pulse |
| lim_o | output | 1 | Duty ceiling point pulse |
| gate_o | output | 1 | Gate drive command |
| ramp_o | output | RAMP_W | In-period count used as the compensation ramp |

## Verification
The bench runs a small configuration, 100 clocks nominal with a depth of 7 counts, through more than one full envelope in four stimulus phases. The quiet phase has no blank and no cycle reset. In it the period lengths and on times alone show the triangular sweep, its extremes, its repeat length and the duty ceiling. The cycle-reset phase adds random comparator requests and directed requests placed exactly at and one past the blanking window edge. These separate an ignored request from an accepted one. The blank phase toggles the suppression input and shows that starts vanish while the ramp and envelope carry on. A final phase mixes both inputs.

// File: rtl/pwm_osc_pkg.sv
package pwm_osc_pkg;

  typedef enum logic {
    SWEEP_UP = 1'b0,
    SWEEP_DN = 1'b1
  } sweep_dir_e;

  function automatic int calc_step_div(input int env_periods, input int jit_max);
    int d;
    if (jit_max <= 0) return 1;
    d = env_periods / (4 * jit_max);
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pwm_jitter_env.sv
module pwm_jitter_env
  import pwm_osc_pkg::*;
#(
  parameter int JIT_MAX  = 28,
  parameter int STEP_DIV = 2,
  parameter int OW       = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  output logic signed [OW-1:0] off_o
);
  localparam int DW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  generate
    if (JIT_MAX > 0) begin : g_sweep
      logic signed [OW-1:0] off_q, off_n;
      logic [DW-1:0]        div_q, div_n;
      sweep_dir_e           dir_q, dir_n;

      always_comb begin
        off_n = off_q;
        div_n = div_q;
        dir_n = dir_q;
        if (step_i) begin
          if (div_q == DW'(STEP_DIV - 1)) begin
            div_n = '0;
            if (dir_q == SWEEP_UP) begin
              off_n = off_q + OW'(1);
              if (off_q == OW'(JIT_MAX - 1)) dir_n = SWEEP_DN;
            end else begin
              off_n = off_q - OW'(1);
              if (off_q == OW'(1 - JIT_MAX)) dir_n = SWEEP_UP;
            end
          end else begin
            div_n = div_q + DW'(1);
          end
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          off_q <= '0;
          div_q <= '0;
          dir_q <= SWEEP_UP;
        end else if (step_i) begin
          off_q <= off_n;
          div_q <= div_n;
          dir_q <= dir_n;
        end
      end

      assign off_o = off_q;
    end else begin : g_flat
      assign off_o = '0;
    end
  endgenerate
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int NOM_PER  = 400,
  parameter int DUTY_PCT = 75,
  parameter int CW       = 9,
  parameter int OW       = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [OW-1:0] off_i,
  output logic [CW-1:0]        ramp_o,
  output logic                 wrap_o,
  output logic [CW-1:0]        per_o,
  output logic [CW-1:0]        lim_o
);
  localparam logic [CW-1:0] NOM_LIM = CW'((NOM_PER * DUTY_PCT) / 100);

  logic [CW-1:0]      cnt_q, cnt_n;
  logic [CW-1:0]      per_q, per_n;
  logic [CW-1:0]      lim_q, lim_n;
  logic signed [CW:0] per_sum;
  logic               wrap;

  assign wrap    = (cnt_q == per_q - CW'(1));
  assign per_sum = $signed({1'b0, CW'(NOM_PER)}) + (CW+1)'(off_i);

  always_comb begin
    cnt_n = cnt_q + CW'(1);
    per_n = per_q;
    lim_n = lim_q;
    if (wrap) begin
      cnt_n = '0;
      per_n = per_sum[CW-1:0];
      lim_n = CW'((32'(per_sum[CW-1:0]) * DUTY_PCT) / 100);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= CW'(NOM_PER);
      lim_q <= NOM_LIM;
    end else begin
      cnt_q <= cnt_n;
      if (wrap) begin
        per_q <= per_n;
        lim_q <= lim_n;
      end
    end
  end

  assign ramp_o = cnt_q;
  assign wrap_o = wrap;
  assign per_o  = per_q;
  assign lim_o  = lim_q;
endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl #(
  parameter int CW       = 9,
  parameter int LEB_CLKS = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] ramp_i,
  input  logic [CW-1:0] lim_i,
  input  logic          blank_i,
  input  logic          cyc_rst_i,
  output logic          set_o,
  output logic          lim_o,
  output logic          gate_o
);
  logic on_q, on_n;
  logic start, at_lim, past_leb;

  assign start    = (ramp_i == '0);
  assign at_lim   = (ramp_i == lim_i);
  assign past_leb = (ramp_i > CW'(LEB_CLKS));

  always_comb begin
    on_n = on_q;
    if (start && !blank_i)                  on_n = 1'b1;
    else if (at_lim)                        on_n = 1'b0;
    else if (on_q && cyc_rst_i && past_leb) on_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) on_q <= 1'b0;
    else         on_q <= on_n;
  end

  assign set_o  = start && !blank_i && rst_ni;
  assign lim_o  = at_lim;
  assign gate_o = on_q;
endmodule

// File: rtl/pwm_jitter_osc.sv
module pwm_jitter_osc
  import pwm_osc_pkg::*;
#(
  parameter int  CLK_HZ   = 26_000_000,
  parameter int  F_SW_HZ  = 65_000,
  parameter int  JIT_PCT  = 7,
  parameter int  ENV_US   = 4000,
  parameter int  DUTY_PCT = 75,
  parameter int  LEB_NS   = 300,
  localparam int NOM_PER  = CLK_HZ / F_SW_HZ,
  localparam int JIT_MAX  = (NOM_PER * JIT_PCT) / 100,
  localparam int RAMP_W   = $clog2(NOM_PER + JIT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_i,
  input  logic              cyc_rst_i,
  output logic              set_o,
  output logic              lim_o,
  output logic              gate_o,
  output logic [RAMP_W-1:0] ramp_o
);
  localparam int ENV_PER  = (ENV_US * (F_SW_HZ / 1000)) / 1000;
  localparam int STEP_DIV = calc_step_div(ENV_PER, JIT_MAX);
  localparam int LEB_CLKS = ((CLK_HZ / 1000) * LEB_NS) / 1_000_000;
  localparam int CW       = RAMP_W;
  localparam int OW       = $clog2(JIT_MAX + 1) + 1;

  logic                 rst_s;
  logic                 wrap;
  logic signed [OW-1:0] off_q;
  logic [CW-1:0]        per_q;
  logic [CW-1:0]        dmax_q;
  logic [CW-1:0]        ramp;

  pwm_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  pwm_jitter_env #(
    .JIT_MAX  (JIT_MAX),
    .STEP_DIV (STEP_DIV),
    .OW       (OW)
  ) u_env (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .step_i (wrap),
    .off_o  (off_q)
  );

  pwm_period_ctr #(
    .NOM_PER  (NOM_PER),
    .DUTY_PCT (DUTY_PCT),
    .CW       (CW),
    .OW       (OW)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .off_i  (off_q),
    .ramp_o (ramp),
    .wrap_o (wrap),
    .per_o  (per_q),
    .lim_o  (dmax_q)
  );

  pwm_gate_ctl #(
    .CW       (CW),
    .LEB_CLKS (LEB_CLKS)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_s),
    .ramp_i    (ramp),
    .lim_i     (dmax_q),
    .blank_i   (blank_i),
    .cyc_rst_i (cyc_rst_i),
    .set_o     (set_o),
    .lim_o     (lim_o),
    .gate_o    (gate_o)
  );

  assign ramp_o = ramp;
endmodule

// File: rtl/pwm_jitter_osc_chk.sv
module pwm_jitter_osc_chk #(
  parameter int CW       = 9,
  parameter int OW       = 6,
  parameter int JIT_MAX  = 28,
  parameter int LEB_CLKS = 7
) (
  input logic                 clk_i,
  input logic                 rst_s,
  input logic                 blank_i,
  input logic                 set_o,
  input logic                 gate_o,
  input logic [CW-1:0]        ramp_o,
  input logic [CW-1:0]        per_q,
  input logic [CW-1:0]        dmax_q,
  input logic signed [OW-1:0] off_q
);
  a_r2_ramp_step: assert property (@(posedge clk_i) disable iff (!rst_s)
    (ramp_o != '0) |-> (ramp_o == $past(ramp_o) + CW'(1)));

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_s)
    (ramp_o == per_q - CW'(1)) |=> (ramp_o == '0));

  a_r4_offset_bounds: assert property (@(posedge clk_i) disable iff (!rst_s)
    ($signed(off_q) <= JIT_MAX) && ($signed(off_q) >= -JIT_MAX));

  a_r6_period_held: assert property (@(posedge clk_i) disable iff (!rst_s)
    (ramp_o != '0) |-> ($stable(per_q) && $stable(dmax_q)));

  a_r7_blank_no_set: assert property (@(posedge clk_i) disable iff (!rst_s)
    blank_i |-> !set_o);

  a_r8_gate_window: assert property (@(posedge clk_i) disable iff (!rst_s)
    gate_o |-> ((ramp_o != '0) && (ramp_o <= dmax_q)));

  a_r9_leb_hold: assert property (@(posedge clk_i) disable iff (!rst_s)
    (gate_o && (ramp_o <= CW'(LEB_CLKS)) && (ramp_o != dmax_q)) |=> gate_o);
endmodule

bind pwm_jitter_osc pwm_jitter_osc_chk #(
  .CW       (CW),
  .OW       (OW),
  .JIT_MAX  (JIT_MAX),
  .LEB_CLKS (LEB_CLKS)
) chk_i (
  .clk_i   (clk_i),
  .rst_s   (rst_s),
  .blank_i (blank_i),
  .set_o   (set_o),
  .gate_o  (gate_o),
  .ramp_o  (ramp_o),
  .per_q   (per_q),
  .dmax_q  (dmax_q),
  .off_q   (off_q)
);

// File: tb/pwm_jitter_osc_tb.sv
module pwm_jitter_osc_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam int P_CLK  = 6_500_000;
  localparam int P_FSW  = 65_000;
  localparam int P_JIT  = 7;
  localparam int P_ENV  = 4000;
  localparam int P_DUTY = 75;
  localparam int P_LEB  = 1000;

  // counts expected from the requirement formulas
  localparam int NOM  = P_CLK / P_FSW;                    // 100
  localparam int JIT  = NOM * P_JIT / 100;                // 7
  localparam int ENVP = P_ENV * P_FSW / 1_000_000;        // 260
  localparam int SDIV = (ENVP / (4 * JIT) < 1) ? 1 : ENVP / (4 * JIT); // 9
  localparam int LEB  = (P_CLK / 1000) * P_LEB / 1_000_000; // 6
  localparam int RW   = $clog2(NOM + JIT + 1);
  localparam int NPER = 400;

  logic          clk;
  logic          rst_n;
  logic          blank;
  logic          crst;
  logic          set_w, lim_w, gate_w;
  logic [RW-1:0] ramp_w;

  int total = 0;
  int bad   = 0;

  pwm_jitter_osc #(
    .CLK_HZ   (P_CLK),
    .F_SW_HZ  (P_FSW),
    .JIT_PCT  (P_JIT),
    .ENV_US   (P_ENV),
    .DUTY_PCT (P_DUTY),
    .LEB_NS   (P_LEB)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .blank_i   (blank),
    .cyc_rst_i (crst),
    .set_o     (set_w),
    .lim_o     (lim_w),
    .gate_o    (gate_w),
    .ramp_o    (ramp_w)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired before end of run");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mcnt, mper, mdmax, moff, mdiv, mon, non;
    bit mup;
    int cyc, pidx, last_start, len, gcnt, prev_dmax;
    int minlen, maxlen, prev_len, max_first, max_second;

    blank = 1'b0;
    crst  = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ramp_w == 0, "R1 ramp in reset", int'(ramp_w), 0);
    chk(gate_w == 0, "R1 gate in reset", int'(gate_w), 0);
    chk(set_w == 0,  "R1 set in reset",  int'(set_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ramp_w == 0 && gate_w == 0 && set_w == 0, "R1 during release",
        int'({ramp_w, gate_w, set_w}), 0);
    @(negedge clk);

    mcnt = 0; mper = NOM; mdmax = NOM * P_DUTY / 100;
    moff = 0; mdiv = 0; mup = 1'b1; mon = 0;
    cyc = 0; pidx = 0; last_start = -1; gcnt = 0; prev_dmax = mdmax;
    minlen = 1 << 30; maxlen = 0; prev_len = 0; max_first = -1; max_second = -1;

    while (pidx < NPER) begin
      // R2 ramp, R7 set, R8 R9 gate, R10 limit point
      chk(int'(ramp_w) == mcnt, "R2 ramp", int'(ramp_w), mcnt);
      chk(int'(set_w) == ((mcnt == 0 && !blank) ? 1 : 0), "R7 set", int'(set_w),
          (mcnt == 0 && !blank) ? 1 : 0);
      chk(int'(gate_w) == mon, "R8 R9 gate", int'(gate_w), mon);
      chk(int'(lim_w) == ((mcnt == mdmax) ? 1 : 0), "R10 limit pulse", int'(lim_w),
          (mcnt == mdmax) ? 1 : 0);

      if (ramp_w == 0) begin
        if (last_start >= 0) begin
          len = cyc - last_start;
          if (pidx == 1) chk(len == NOM, "R3 first period", len, NOM);
          if (pidx >= 1 && pidx < 100)
            chk(gcnt == prev_dmax, "R8 on time", gcnt, prev_dmax);
          if (len < minlen) minlen = len;
          if (len > maxlen) maxlen = len;
          if (len == NOM + JIT && prev_len != NOM + JIT) begin
            if (max_first < 0) max_first = pidx;
            else if (max_second < 0) max_second = pidx;
          end
          prev_len = len;
        end
        gcnt = 0;
        prev_dmax = mdmax;
        pidx++;
        last_start = cyc;
      end
      if (gate_w) gcnt++;

      // stimulus by phase
      blank = 1'b0;
      crst  = 1'b0;
      if (pidx >= 100 && pidx < 200) begin
        crst = ($urandom_range(0, 15) == 0);
        if (pidx % 4 == 1 && mcnt == LEB)     crst = 1'b1; // R9 ignored at edge
        if (pidx % 4 == 2 && mcnt == LEB + 1) crst = 1'b1; // R9 accepted
      end else if (pidx >= 200 && pidx < 300) begin
        blank = ($urandom_range(0, 3) == 0);
        if (pidx % 3 == 0 && mcnt == 0) blank = 1'b1;      // R7 suppressed start
      end else if (pidx >= 300) begin
        blank = ($urandom_range(0, 5) == 0);
        crst  = ($urandom_range(0, 9) == 0);
      end

      // reference update for the coming edge
      non = mon;
      if (mcnt == 0 && !blank)                  non = 1;
      else if (mcnt == mdmax)                   non = 0;
      else if (mon == 1 && crst && mcnt > LEB)  non = 0;
      mon = non;
      if (mcnt == mper - 1) begin
        mcnt  = 0;
        mper  = NOM + moff;
        mdmax = mper * P_DUTY / 100;
        if (mdiv == SDIV - 1) begin
          mdiv = 0;
          if (mup) begin
            moff++;
            if (moff == JIT) mup = 1'b0;
          end else begin
            moff--;
            if (moff == -JIT) mup = 1'b1;
          end
        end else begin
          mdiv++;
        end
      end else begin
        mcnt++;
      end

      cyc++;
      @(negedge clk);
    end

    chk(minlen == NOM - JIT, "R4 shortest period", minlen, NOM - JIT);
    chk(maxlen == NOM + JIT, "R4 longest period", maxlen, NOM + JIT);
    chk(max_second - max_first == 4 * JIT * SDIV, "R5 envelope repeat",
        max_second - max_first, 4 * JIT * SDIV);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule